// File: doc/BRIEF.md
# External Interrupt Pin Conditioner

This block takes four asynchronous external interrupt pins and turns each one into a clean, single-clock request line. A single 32-bit control word configures all four pins. For each pin the word holds a sense selector, an enable bit and a clear bit that empties the pin's request latch. The same word also holds a global gate for all external requests and a routing selector for the critical pin.

Each pin passes through a two-flop synchronizer. In the level sense codes the request follows the synchronized pin, either directly or inverted. In the edge sense codes a detected rising or falling edge sets a sticky latch. The latch holds its request until software writes the pin's clear bit.

Pin 0 feeds the critical interrupt group. Pins 1 to 3 feed the main interrupt group as its sources 1 to 3. Priority encoding of the groups is done elsewhere.

Top module: `exti_conditioner`

## Requirements
- R1: After reset the control word reads 0x00000000, every pin is disabled with sense code 0, and all request outputs are low.
- R2: Control layout. The 2-bit sense code of pin n sits at bits [23-2n:22-2n]. The enable of pin n is bit 11-n. The master enable is bit 12. The critical routing select is bit 0. A write stores these fields, reading returns them, and every other bit reads as 0.
- R3: Sense code 0 makes the request follow the pin high, and sense code 3 makes it follow the pin low. A pin change driven before clock edge k shows at the outputs after edge k+1, and not after edge k.
- R4: Sense code 1 latches rising edges and sense code 2 latches falling edges. A pin change driven before edge k sets the request after edge k+2. The request stays set after the pin returns, and the opposite edge sets nothing.
- R5: Writing 1 to bit 27-n clears the latched request of pin n only. Clear bits are not stored and always read back as 0.
- R6: When a clear of pin n and a new edge on pin n arrive at the same clock edge, the latch stays set.
- R7: A request reaches an output only while both its pin enable and the master enable are 1. An edge that arrives while the pin is disabled is still latched, and it is forwarded once the pin is enabled.
- R8: Pin 0 drives crit_req when the routing select is 1 and crit_alt_req when it is 0. Pins 1, 2 and 3 drive main_req[0], main_req[1] and main_req[2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 4 | Raw external interrupt pins, asynchronous |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_rdata | output | 32 | Control word read data |
| crit_req | output | 1 | Pin 0 request on the normal critical route |
| crit_alt_req | output | 1 | Pin 0 request when normal critical routing is off |
| main_req | output | 3 | Requests of pins 1 to 3 toward the main group |

## Verification
A wrong internal state shows up at the ports quickly:
- A corrupt stored field shows in cfg_rdata one cycle after the write.
- A synchronizer with the wrong depth moves level-mode requests away from the expected edge by a cycle or more.
- A latch that misses an edge, or that clears when it should hold, shows on the request lines within three clock edges of the pin change.
- A latch wrongly gated by the enable bits only shows when the pin is later enabled. The bench therefore latches edges while the pins are disabled and enables the pins afterwards.

// File: rtl/exti_pkg.sv
package exti_pkg;

  parameter int unsigned EXT_PINS  = 4;
  parameter int unsigned CFG_W     = 32;

  // control word field anchors (pin 0 position, fields move down with pin index)
  localparam int unsigned SENSE_LO0 = 22;
  localparam int unsigned EN_BIT0   = 11;
  localparam int unsigned CLR_BIT0  = 27;
  localparam int unsigned MEE_BIT   = 12;
  localparam int unsigned ROUTE_BIT = 0;

  typedef enum logic [1:0] {
    SENSE_HIGH = 2'd0,
    SENSE_RISE = 2'd1,
    SENSE_FALL = 2'd2,
    SENSE_LOW  = 2'd3
  } sense_e;

  function automatic logic sense_is_edge(input logic [1:0] code);
    return (code == SENSE_RISE) || (code == SENSE_FALL);
  endfunction

endpackage

// File: rtl/exti_sync.sv
module exti_sync #(
  parameter int unsigned NPINS  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  output logic [NPINS-1:0] sync_o
);

  logic [STAGES-1:0][NPINS-1:0] stage_q;
  logic [STAGES-1:0][NPINS-1:0] stage_d;

  always_comb begin
    stage_d[0] = pin_i;
    for (int s = 1; s < STAGES; s++) begin
      stage_d[s] = stage_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign sync_o = stage_q[STAGES-1];

  // cycles since reset, saturating, so the delay check never looks before reset
  logic [1:0] warm_q;
  logic [1:0] warm_d;

  always_comb begin
    warm_d = warm_q;
    if (warm_q != 2'd3) warm_d = warm_q + 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= '0;
    else        warm_q <= warm_d;
  end

  generate
    if (STAGES == 2) begin : g_chk2
      // R3: synchronized value equals the pin two edges earlier
      assert_sync_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd2) |-> (sync_o == $past(pin_i, 2)));
    end
  endgenerate

endmodule

// File: rtl/exti_edge_cell.sv
module exti_edge_cell
  import exti_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_i,
  input  logic [1:0] sense_i,
  input  logic       clr_i,
  output logic       req_o
);

  logic prev_q;
  logic pend_q;
  logic pend_d;
  logic rise_det;
  logic fall_det;
  logic edge_hit;

  assign rise_det = sync_i & ~prev_q;
  assign fall_det = ~sync_i & prev_q;

  always_comb begin
    edge_hit = 1'b0;
    case (sense_i)
      SENSE_RISE: edge_hit = rise_det;
      SENSE_FALL: edge_hit = fall_det;
      default:    edge_hit = 1'b0;
    endcase
  end

  // set beats clear
  always_comb begin
    pend_d = pend_q;
    if (edge_hit)   pend_d = 1'b1;
    else if (clr_i) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= sync_i;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    case (sense_i)
      SENSE_HIGH: req_o = sync_i;
      SENSE_LOW:  req_o = ~sync_i;
      default:    req_o = pend_q;
    endcase
  end

  assert_edge_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_is_edge(sense_i) && ((sense_i == SENSE_RISE) ? rise_det : fall_det))
      |=> pend_q);

  assert_clear_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !edge_hit) |=> !pend_q);

  assert_edge_beats_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && edge_hit) |=> pend_q);

endmodule

// File: rtl/exti_cfg_reg.sv
module exti_cfg_reg
  import exti_pkg::*;
#(
  parameter int unsigned NPINS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_i,
  input  logic [CFG_W-1:0]      wdata_i,
  output logic [CFG_W-1:0]      rdata_o,
  output logic [NPINS-1:0][1:0] sense_o,
  output logic [NPINS-1:0]      en_o,
  output logic                  mee_o,
  output logic                  route_o,
  output logic [NPINS-1:0]      clr_o
);

  logic [NPINS-1:0][1:0] sense_q, sense_d;
  logic [NPINS-1:0]      en_q, en_d;
  logic                  mee_q, mee_d;
  logic                  route_q, route_d;
  logic [NPINS-1:0][1:0] sense_w;
  logic [NPINS-1:0]      en_w;

  genvar n;
  generate
    for (n = 0; n < NPINS; n++) begin : g_field
      localparam int unsigned SLO = SENSE_LO0 - 2*n;
      localparam int unsigned EB  = EN_BIT0 - n;
      localparam int unsigned CB  = CLR_BIT0 - n;
      assign sense_w[n] = wdata_i[SLO +: 2];
      assign en_w[n]    = wdata_i[EB];
      assign clr_o[n]   = we_i & wdata_i[CB];

      always_comb begin
        rdata_field[n] = '0;
        rdata_field[n][SLO +: 2] = sense_q[n];
        rdata_field[n][EB]       = en_q[n];
      end

      assert_wr_sense_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (sense_q[n] == $past(wdata_i[SLO +: 2])));
      assert_wr_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (en_q[n] == $past(wdata_i[EB])));
    end
  endgenerate

  logic [NPINS-1:0][CFG_W-1:0] rdata_field;

  always_comb begin
    sense_d = sense_q;
    en_d    = en_q;
    mee_d   = mee_q;
    route_d = route_q;
    if (we_i) begin
      sense_d = sense_w;
      en_d    = en_w;
      mee_d   = wdata_i[MEE_BIT];
      route_d = wdata_i[ROUTE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      en_q    <= '0;
      mee_q   <= 1'b0;
      route_q <= 1'b0;
    end else begin
      sense_q <= sense_d;
      en_q    <= en_d;
      mee_q   <= mee_d;
      route_q <= route_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NPINS; i++) begin
      rdata_o = rdata_o | rdata_field[i];
    end
    rdata_o[MEE_BIT]   = mee_q;
    rdata_o[ROUTE_BIT] = route_q;
  end

  assign sense_o = sense_q;
  assign en_o    = en_q;
  assign mee_o   = mee_q;
  assign route_o = route_q;

endmodule

// File: rtl/exti_conditioner.sv
module exti_conditioner
  import exti_pkg::*;
#(
  parameter int unsigned NPINS       = EXT_PINS,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic             crit_req,
  output logic             crit_alt_req,
  output logic [NPINS-2:0] main_req
);

  logic [NPINS-1:0]      sync_pin;
  logic [NPINS-1:0][1:0] sense;
  logic [NPINS-1:0]      pin_en;
  logic [NPINS-1:0]      clr;
  logic [NPINS-1:0]      raw_req;
  logic [NPINS-1:0]      gated_req;
  logic                  mee;
  logic                  route;

  exti_cfg_reg #(.NPINS(NPINS)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (cfg_we),
    .wdata_i (cfg_wdata),
    .rdata_o (cfg_rdata),
    .sense_o (sense),
    .en_o    (pin_en),
    .mee_o   (mee),
    .route_o (route),
    .clr_o   (clr)
  );

  exti_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (pin_i),
    .sync_o (sync_pin)
  );

  genvar n;
  generate
    for (n = 0; n < NPINS; n++) begin : g_cell
      exti_edge_cell u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_i  (sync_pin[n]),
        .sense_i (sense[n]),
        .clr_i   (clr[n]),
        .req_o   (raw_req[n])
      );
    end
  endgenerate

  assign gated_req    = raw_req & pin_en & {NPINS{mee}};
  assign crit_req     = gated_req[0] & route;
  assign crit_alt_req = gated_req[0] & ~route;
  assign main_req     = gated_req[NPINS-1:1];

  assert_crit_one_route_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({crit_req, crit_alt_req}));

endmodule

// File: tb/exti_conditioner_bench.sv
module exti_conditioner_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  pin_i;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        crit_req;
  logic        crit_alt_req;
  logic [2:0]  main_req;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  exti_conditioner u_exti_conditioner (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_i        (pin_i),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .crit_req     (crit_req),
    .crit_alt_req (crit_alt_req),
    .main_req     (main_req)
  );

  localparam logic [31:0] RD_MASK = 32'h00FF_1F01;

  // {control word, pins[3:0], expected {crit, crit_alt, main[2:0]}}
  localparam int NV = 15;
  localparam logic [40:0] VEC [NV] = '{
    {32'h0000_1F01, 4'b0000, 5'b00000},
    {32'h0000_1F01, 4'b1111, 5'b10111},
    {32'h0000_1F01, 4'b0101, 5'b10010},
    {32'h0000_1F00, 4'b0101, 5'b01010},
    {32'h00FF_1F01, 4'b0101, 5'b00101},
    {32'h00FF_0F01, 4'b0101, 5'b00000},
    {32'h00FF_1301, 4'b0000, 5'b00110},
    {32'h0F55_1F01, 4'b0011, 5'b10001},
    {32'h0055_1F01, 4'b0000, 5'b10001},
    {32'h0455_1F01, 4'b0000, 5'b10000},
    {32'h0FAA_1F01, 4'b1100, 5'b00000},
    {32'h00AA_1F01, 4'b0000, 5'b00110},
    {32'h0FAA_1001, 4'b1111, 5'b00000},
    {32'h00AA_1001, 4'b0000, 5'b00000},
    {32'h00AA_1F01, 4'b0000, 5'b10111}
  };

  function automatic string req_of(int idx);
    case (idx)
      0, 1, 2, 3: return "R3";
      5, 6:       return "R7";
      7, 8, 10, 11: return "R4";
      9:          return "R5";
      12, 13, 14: return "R7";
      default:    return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] outs();
    return {27'd0, crit_req, crit_alt_req, main_req};
  endfunction

  task automatic write_cfg(input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    pin_i = '0;
    cfg_we = 1'b0;
    cfg_wdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", cfg_rdata, 32'h0);
    check("R1", outs(), 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", outs(), 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = VEC[i][40:9];
      pin_i = VEC[i][8:5];
      @(negedge clk);
      cfg_we = 1'b0;
      repeat (4) @(negedge clk);
      check(req_of(i), outs(), {27'd0, VEC[i][4:0]});
      check("R2", cfg_rdata, VEC[i][40:9] & RD_MASK);
    end

    // R3: level latency, pin change before edge k visible after k+1
    write_cfg(32'h0F00_1F01);
    repeat (4) @(negedge clk);
    check("R3", outs(), 32'h0);
    pin_i = 4'b0010;
    @(negedge clk);
    check("R3", outs(), 32'h0);
    @(negedge clk);
    check("R3", outs(), 32'h1);

    // R4 / R6: edge latency and clear colliding with a new edge
    pin_i = 4'b0000;
    write_cfg(32'h0F55_1F01);
    repeat (4) @(negedge clk);
    check("R4", outs(), 32'h0);
    pin_i = 4'b0001;
    @(negedge clk);
    @(negedge clk);
    check("R4", outs(), 32'h0);
    cfg_we = 1'b1;
    cfg_wdata = 32'h0855_1F01;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R6", outs(), 32'h10);
    @(negedge clk);
    check("R6", outs(), 32'h10);

    // R5: clear alone empties latch, clear bits read as 0
    write_cfg(32'h0855_1F01);
    check("R5", outs(), 32'h0);
    check("R5", cfg_rdata, 32'h0055_1F01);

    // R8: routing flip of a held latch
    pin_i = 4'b0000;
    repeat (3) @(negedge clk);
    pin_i = 4'b0001;
    repeat (4) @(negedge clk);
    check("R8", outs(), 32'h10);
    write_cfg(32'h0055_1F00);
    check("R8", outs(), 32'h08);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule